// File: doc/BRIEF.md
# Receive Descriptor Ring Tracker

This block keeps the pointer state of a circular ring of receive descriptors in a network receive path. Software hands free descriptors to the hardware by writing a new tail index. For each arriving packet the block works out how many descriptors the packet occupies at the programmed buffer size, consumes them by moving the head index forward, and wraps the head at the end of the ring. The number of free descriptors is always available at the output.

A low-free interrupt flag is raised when the free count lands exactly on a selectable fraction of the ring length. The flag holds until software clears it. A packet that cannot be placed, because too few descriptors are free or because the buffer size code is the reserved one, is dropped. The head does not move and a one-cycle drop pulse is produced. Descriptor contents, DMA and memory traffic are handled elsewhere.

Top module: `rx_ring_tracker`

## Requirements
- R1: After reset the head index, tail index, free count, interrupt flag and drop pulse are all zero. The configuration resets to size code 00, extension 0 and threshold code 00.
- R2: With the extension bit at 0, size codes 00, 01, 10 and 11 select buffers of 2048, 1024, 512 and 256 bytes.
- R3: With the extension bit at 1, size codes 01, 10 and 11 select buffers of 16384, 8192 and 4096 bytes. Code 00 is reserved: every packet offered under it is dropped and the head holds.
- R4: A packet consumes ceil(length / buffer size) descriptors. A packet of length zero consumes none and is not dropped.
- R5: The free count equals (tail - head) modulo the ring length. It reflects a tail write or a packet on the clock edge that takes it, and stays unchanged in cycles with neither.
- R6: An accepted packet advances the head by its descriptor count modulo the ring length, so the head wraps to zero past the last entry.
- R7: A packet needing more descriptors than are free is dropped. The head is unchanged, and the drop output is high for exactly the one cycle after the edge that took the packet.
- R8: Threshold codes 00, 01 and 10 select the ring length shifted right by 1, 2 or 3 (32, 16 and 8 for a 64-entry ring). The interrupt is set on the edge where the free count changes to that value. Code 11 never sets it.
- R9: The interrupt flag stays set until a cycle with the clear strobe. A new set condition on the same edge as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load the configuration fields |
| cfg_bsize_i | input | 2 | Buffer size code |
| cfg_bext_i | input | 1 | Buffer size extension bit |
| cfg_thr_i | input | 2 | Low-free threshold code |
| tail_we_i | input | 1 | Load a new tail index |
| tail_i | input | IDX_W | New tail index |
| irq_clr_i | input | 1 | Clear the interrupt flag |
| pkt_valid_i | input | 1 | A packet length is offered |
| pkt_len_i | input | LEN_W | Packet length in bytes |
| head_o | output | IDX_W | Head index |
| free_o | output | IDX_W | Free descriptor count |
| irq_o | output | 1 | Sticky low-free interrupt flag |
| drop_o | output | 1 | One-cycle pulse for a dropped packet |

## Verification
Every result of a stimulus is due after a single clock edge. The head index, free count, interrupt flag and drop pulse all come from registers loaded on the edge that takes the packet, tail write, clear or configuration write. A configuration write affects only the packets offered after it. The driver applies each stimulus just after a falling edge and queues the expected head, free count, flag and drop values for that edge. The monitor pops one entry a quarter period after each rising edge while the queue holds one, so each comparison lines up with exactly one edge.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef struct packed {
    logic [1:0] bsize;
    logic       bext;
    logic [1:0] thr;
  } rx_cfg_t;

  localparam int unsigned SHIFT_W = 4;
endpackage

// File: rtl/rx_buf_decode.sv
module rx_buf_decode
  import rx_ring_pkg::*;
(
  input  logic [1:0]         bsize_i,
  input  logic               bext_i,
  output logic [SHIFT_W-1:0] shift_o,
  output logic               valid_o
);
  // log2 of the buffer size in bytes
  always_comb begin
    if (bext_i) shift_o = SHIFT_W'(4'd15 - {2'b00, bsize_i});
    else        shift_o = SHIFT_W'(4'd11 - {2'b00, bsize_i});
    valid_o = !(bext_i && bsize_i == 2'b00);
  end
endmodule

// File: rtl/rx_desc_count.sv
module rx_desc_count
  import rx_ring_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic [LEN_W-1:0]   len_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [LEN_W-1:0]   need_o
);
  logic [LEN_W-1:0] rem_mask;

  always_comb begin
    rem_mask = ~({LEN_W{1'b1}} << shift_i);
    need_o   = (len_i >> shift_i) + LEN_W'(|(len_i & rem_mask));
  end
endmodule

// File: rtl/rx_ring_ptrs.sv
module rx_ring_ptrs #(
  parameter int unsigned RING_LEN = 64,
  parameter int unsigned IDX_W    = $clog2(RING_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tail_we_i,
  input  logic [IDX_W-1:0] tail_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] adv_cnt_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] free_o,
  output logic [IDX_W-1:0] free_nxt_o
);
  localparam logic [IDX_W:0] RING_EXT = (IDX_W+1)'(RING_LEN);

  logic [IDX_W-1:0] head_q, tail_q, head_d, tail_d;
  logic [IDX_W:0]   head_sum;

  function automatic logic [IDX_W-1:0] ring_dist(logic [IDX_W-1:0] t, logic [IDX_W-1:0] h);
    logic [IDX_W:0] d;
    if (t >= h) d = {1'b0, t} - {1'b0, h};
    else        d = {1'b0, t} + RING_EXT - {1'b0, h};
    return d[IDX_W-1:0];
  endfunction

  always_comb begin
    head_sum = {1'b0, head_q} + {1'b0, adv_cnt_i};
    if (head_sum >= RING_EXT) head_sum = head_sum - RING_EXT;
    head_d = adv_i ? head_sum[IDX_W-1:0] : head_q;
    tail_d = (tail_we_i && ({1'b0, tail_i} < RING_EXT)) ? tail_i : tail_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign head_o     = head_q;
  assign free_o     = ring_dist(tail_q, head_q);
  assign free_nxt_o = ring_dist(tail_d, head_d);

  assert_head_in_ring_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, head_q} < RING_EXT);

  assert_free_idle_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !tail_we_i) |=> $stable(free_o));
endmodule

// File: rtl/rx_low_thresh.sv
module rx_low_thresh #(
  parameter int unsigned RING_LEN = 64,
  parameter int unsigned IDX_W    = $clog2(RING_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       thr_code_i,
  input  logic [IDX_W-1:0] free_i,
  input  logic [IDX_W-1:0] free_nxt_i,
  input  logic             clr_i,
  output logic             irq_o
);
  logic [IDX_W-1:0] thr_val;
  logic             thr_en, hit, irq_q;

  always_comb begin
    thr_en = 1'b1;
    unique case (thr_code_i)
      2'b00:   thr_val = IDX_W'(RING_LEN >> 1);
      2'b01:   thr_val = IDX_W'(RING_LEN >> 2);
      2'b10:   thr_val = IDX_W'(RING_LEN >> 3);
      default: begin thr_val = '0; thr_en = 1'b0; end
    endcase
    hit = thr_en && (free_nxt_i == thr_val) && (free_nxt_i != free_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (hit)   irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  assert_irq_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_i) |=> irq_q);

  assert_reserved_thr_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_code_i == 2'b11 && !irq_q) |=> !irq_q);

  assert_irq_at_threshold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> (free_i == $past(thr_val)));
endmodule

// File: rtl/rx_ring_tracker.sv
module rx_ring_tracker
  import rx_ring_pkg::*;
#(
  parameter int unsigned RING_LEN = 64,
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned IDX_W    = $clog2(RING_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_bsize_i,
  input  logic             cfg_bext_i,
  input  logic [1:0]       cfg_thr_i,
  input  logic             tail_we_i,
  input  logic [IDX_W-1:0] tail_i,
  input  logic             irq_clr_i,
  input  logic             pkt_valid_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] free_o,
  output logic             irq_o,
  output logic             drop_o
);
  rx_cfg_t            cfg_q;
  logic [SHIFT_W-1:0] buf_shift;
  logic               buf_ok, fits, accept, drop_q;
  logic [LEN_W-1:0]   need;
  logic [IDX_W-1:0]   free_cur, free_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= '{bsize: cfg_bsize_i, bext: cfg_bext_i, thr: cfg_thr_i};
  end

  rx_buf_decode u_dec (
    .bsize_i (cfg_q.bsize),
    .bext_i  (cfg_q.bext),
    .shift_o (buf_shift),
    .valid_o (buf_ok)
  );

  rx_desc_count #(.LEN_W(LEN_W)) u_cnt (
    .len_i   (pkt_len_i),
    .shift_i (buf_shift),
    .need_o  (need)
  );

  always_comb begin
    fits   = need <= LEN_W'(free_cur);
    accept = pkt_valid_i && buf_ok && fits;
  end

  rx_ring_ptrs #(.RING_LEN(RING_LEN), .IDX_W(IDX_W)) u_ptrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tail_we_i  (tail_we_i),
    .tail_i     (tail_i),
    .adv_i      (accept),
    .adv_cnt_i  (need[IDX_W-1:0]),
    .head_o     (head_o),
    .free_o     (free_cur),
    .free_nxt_o (free_nxt)
  );

  rx_low_thresh #(.RING_LEN(RING_LEN), .IDX_W(IDX_W)) u_thr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .thr_code_i (cfg_q.thr),
    .free_i     (free_cur),
    .free_nxt_i (free_nxt),
    .clr_i      (irq_clr_i),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drop_q <= 1'b0;
    else         drop_q <= pkt_valid_i && !accept;
  end

  assign free_o = free_cur;
  assign drop_o = drop_q;

  assert_reserved_size_drops_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !buf_ok) |=> drop_o);

  assert_drop_holds_head_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> $stable(head_o));

  assert_drop_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_i |=> !drop_o);
endmodule

// File: tb/tb_rx_ring_tracker.sv
module tb_rx_ring_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic clk = 0, rst_ni = 0;
  logic cfg_we = 0, bext = 0, tail_we = 0, clr = 0, pv = 0;
  logic [1:0] bsize = 0, thr = 0;
  logic [5:0] tail = 0;
  logic [15:0] len = 0;
  logic [5:0] head_o, free_o;
  logic irq_o, drop_o;

  int checks = 0, errors = 0;
  int m_head = 0, m_tail = 0, m_bs = 0, m_ext = 0, m_thr = 0;
  bit m_irq = 0;

  typedef struct { string tag; int head; int free; bit irq; bit drop; } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_tracker dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_bsize_i(bsize),
    .cfg_bext_i(bext), .cfg_thr_i(thr), .tail_we_i(tail_we), .tail_i(tail),
    .irq_clr_i(clr), .pkt_valid_i(pv), .pkt_len_i(len), .head_o(head_o),
    .free_o(free_o), .irq_o(irq_o), .drop_o(drop_o)
  );

  function automatic int buf_bytes(int ext, int code);
    if (ext == 0) return 2048 >> code;
    if (code == 0) return 0;
    return 32768 >> code;
  endfunction

  function automatic int mfree();
    return (m_tail - m_head + N) % N;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: inputs are set just after a falling edge; model the next edge
  task automatic go(string tag);
    int sz, need, f_old, f_new, thv;
    bit drop;
    exp_t e;
    sz = buf_bytes(m_ext, m_bs);
    f_old = mfree();
    drop = 0;
    if (pv) begin
      if (sz == 0) drop = 1;
      else begin
        need = (int'(len) + sz - 1) / sz;
        if (need > f_old) drop = 1;
        else m_head = (m_head + need) % N;
      end
    end
    if (tail_we) m_tail = int'(tail);
    f_new = mfree();
    thv = (m_thr == 3) ? -1 : (N >> (m_thr + 1));
    if (f_new == thv && f_new != f_old) m_irq = 1;
    else if (clr) m_irq = 0;
    if (cfg_we) begin m_bs = int'(bsize); m_ext = int'(bext); m_thr = int'(thr); end
    e.tag = tag; e.head = m_head; e.free = f_new; e.irq = m_irq; e.drop = drop;
    q.push_back(e);
    @(negedge clk);
    cfg_we = 0; tail_we = 0; clr = 0; pv = 0;
  endtask

  task automatic pkt(int l, string tag);
    pv = 1; len = 16'(l); go(tag);
  endtask

  task automatic set_cfg(int ext, int bs, int th, string tag);
    cfg_we = 1; bext = 1'(ext); bsize = 2'(bs); thr = 2'(th); go(tag);
  endtask

  task automatic set_tail(int t, string tag);
    tail_we = 1; tail = 6'(t); go(tag);
  endtask

  // packet sized to bring the free count exactly to target
  task automatic consume_to(int target, bit with_clr, string tag);
    pv = 1; clr = with_clr;
    len = 16'((mfree() - target) * buf_bytes(m_ext, m_bs));
    go(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " head"}, int'(head_o), e.head);
        check({e.tag, " free"}, int'(free_o), e.free);
        check({e.tag, " irq"}, int'(irq_o), int'(e.irq));
        check({e.tag, " drop"}, int'(drop_o), int'(e.drop));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 head", int'(head_o), 0);
    check("R1 free", int'(free_o), 0);
    check("R1 irq", int'(irq_o), 0);
    check("R1 drop", int'(drop_o), 0);
    rst_ni = 1;
    @(negedge clk);
    set_tail(40, "R5 tail write");
    pkt(1500, "R4 one desc");
    pkt(3000, "R4 two desc");
    pkt(2048, "R2 exact 2048");
    pkt(2049, "R2 2049 over");
    pkt(0, "R4 zero length");
    go("R5 idle");
    consume_to(32, 0, "R8 half threshold");
    pkt(100, "R9 sticky");
    clr = 1; go("R9 clear");
    set_cfg(0, 3, 0, "R2 cfg 256");
    pkt(1000, "R2 256 buffers");
    set_cfg(0, 1, 0, "R2 cfg 1024");
    pkt(1025, "R2 1024 buffers");
    set_cfg(0, 2, 0, "R2 cfg 512");
    pkt(512, "R2 512 buffers");
    set_cfg(1, 1, 0, "R3 cfg 16384");
    pkt(20000, "R3 16384 buffers");
    set_cfg(1, 2, 0, "R3 cfg 8192");
    pkt(8193, "R3 8192 buffers");
    set_cfg(1, 3, 0, "R3 cfg 4096");
    pkt(4097, "R3 4096 buffers");
    set_cfg(1, 0, 1, "R3 cfg reserved");
    pkt(100, "R3 reserved drop");
    set_cfg(0, 3, 1, "R8 cfg quarter");
    len = 16'((mfree() + 1) * 256); pv = 1; go("R7 overrun drop");
    go("R7 drop one cycle");
    consume_to(16, 0, "R8 quarter threshold");
    clr = 1; go("R9 clear again");
    set_tail((m_head + 30) % N, "R5 refill");
    consume_to(16, 1, "R9 set beats clear");
    set_cfg(0, 3, 2, "R8 cfg eighth");
    clr = 1; go("R9 clear third");
    consume_to(8, 0, "R8 eighth threshold");
    set_cfg(0, 3, 3, "R8 cfg reserved");
    clr = 1; go("R9 clear fourth");
    set_tail((m_head + 63) % N, "R6 refill full");
    consume_to(32, 0, "R8 reserved at 32");
    consume_to(16, 0, "R8 reserved at 16");
    consume_to(8, 0, "R6 wrap and R8 reserved at 8");
    pkt(2048, "R6 small step");
    repeat (3) @(negedge clk);
    check("queue drained", q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule